// File: doc/BRIEF.md
# Modem Status and Control Register Unit

This block keeps the modem-side state of a 16550-style serial port. It brings the four incoming handshake lines (clear-to-send, data-set-ready, carrier-detect, ring) into the clock domain and holds their sampled levels as the upper nibble of an 8-bit status register. Each change of a line is recorded in a sticky change bit in the lower nibble. For the ring line, only the end of a ring (a 1 to 0 transition) is recorded. The change bits stay set until software reads the status register. The read returns the value that was current at that moment, and the clock edge that ends the read cycle clears the change bits. A change that arrives on that same edge is kept, so it is not lost.

The block also holds the 5-bit modem control register. That register drives the four outgoing lines and selects internal loopback. In loopback the outgoing lines go inactive and the incoming lines are ignored. A status read then reflects the control register bits. A single flag tells the interrupt encoder that at least one change bit is pending.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status read value is 0xB0, the control read value is 0x08, out2 is 1, dtr/rts/out1 are 0 and the change flag is 0.
- R2: Outside loopback, status bits 7, 6, 5 and 4 show carrier-detect, ring, data-set-ready and clear-to-send. Each bit is 1 when its line is 1, and a new level appears on the third rising edge after the line changes.
- R3: Any change of clear-to-send, data-set-ready or carrier-detect sets status bit 0, 1 or 3 respectively. These bits are sticky and gather changes of several lines until they are cleared.
- R4: Status bit 2 is set only when the sampled ring level falls from 1 to 0. A rising ring level leaves it clear.
- R5: A cycle with stat_rd_en high returns the current status value, including the change bits. Outside loopback the change bits are 0 after that cycle.
- R6: A change whose detection falls on the same edge as a read-clear is kept in the change bits.
- R7: A control write stores ctl_wr_data[4:0]. Bits 7:5 are ignored, and ctl_rd_data reads the stored value with bits 7:5 as zero.
- R8: The control bits drive the outgoing lines from the cycle after the write: bit 0 drives dtr, bit 1 rts, bit 2 out1 and bit 3 out2. Bit 4 selects loopback.
- R9: In loopback, a status read returns control bit 3 in bit 7, bit 2 in bit 6, bit 0 in bit 5, bit 1 in bit 4, and zero in bits 3:0.
- R10: In loopback all four outgoing lines are 0. Line changes neither update the stored levels nor set change bits, and a read leaves the change bits unchanged. After loopback ends, lines that differ from the held levels raise change bits.
- R11: stat_delta_any is 1 exactly when loopback is off and at least one change bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cts | input | 1 | Clear-to-send line, 1 = asserted, asynchronous |
| line_dsr | input | 1 | Data-set-ready line, 1 = asserted, asynchronous |
| line_dcd | input | 1 | Carrier-detect line, 1 = asserted, asynchronous |
| line_ri | input | 1 | Ring line, 1 = asserted, asynchronous |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write data |
| ctl_rd_data | output | 8 | Control register read value |
| stat_rd_en | input | 1 | Status register read strobe (clears change bits) |
| stat_rd_data | output | 8 | Status register read value |
| pin_dtr | output | 1 | Data-terminal-ready output, 1 = asserted |
| pin_rts | output | 1 | Request-to-send output, 1 = asserted |
| pin_out1 | output | 1 | General output 1, 1 = asserted |
| pin_out2 | output | 1 | General output 2, 1 = asserted |
| stat_delta_any | output | 1 | At least one change bit pending, for the interrupt encoder |

## Verification
The properties assume that the incoming lines already meet setup and hold at the synchronizer, and that read and write strobes last one clock. The bench changes lines and strobes only on falling edges and keeps every strobe to a single cycle. The properties also treat the loopback bit as stable for the whole cycle in which it is sampled, which holds because it comes from a register written on a rising edge. The same-edge read-and-change case is produced by timing the strobe so that it lands on the third rising edge after a line change.

// File: rtl/msu_pkg.sv
package msu_pkg;

  localparam int NLINES = 4;
  localparam int CTL_W  = 5;
  localparam int REG_W  = 8;

  // index of each line inside a nibble (status high nibble and change nibble)
  localparam int IX_CTS = 0;
  localparam int IX_DSR = 1;
  localparam int IX_RI  = 2;
  localparam int IX_DCD = 3;

  // control register fields
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  typedef logic [NLINES-1:0] line_nib_t;

  localparam line_nib_t        LINE_RST = 4'b1011;   // dcd, dsr, cts asserted
  localparam logic [CTL_W-1:0] CTL_RST  = 5'b01000;  // out2 only

endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    for (int k = 0; k < STAGES; k++) begin
      if (k == 0) stg_d[k] = async_i;
      else        stg_d[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/msu_ctrl_reg.sv
module msu_ctrl_reg
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_val,
  output logic [CTL_W-1:0] ctl_q,
  output logic             loop_o,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             out1_o,
  output logic             out2_o
);

  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;

  assign ctl_en = wr_en;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_en) ctl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign loop_o = ctl_q[CB_LOOP];
  // outgoing lines parked inactive while looped back
  assign dtr_o  = ctl_q[CB_DTR]  & ~loop_o;
  assign rts_o  = ctl_q[CB_RTS]  & ~loop_o;
  assign out1_o = ctl_q[CB_OUT1] & ~loop_o;
  assign out2_o = ctl_q[CB_OUT2] & ~loop_o;

endmodule

// File: rtl/msu_status.sv
module msu_status
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  line_nib_t        lines_i,
  input  logic             loop_i,
  input  logic [CTL_W-2:0] ctl_i,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             delta_any,
  output line_nib_t        level_q,
  output line_nib_t        delta_q
);

  line_nib_t level_d;
  line_nib_t delta_d;
  line_nib_t seen;
  line_nib_t loop_view;
  logic      track_en;

  assign track_en = ~loop_i;

  // change detection; ring only on its trailing edge
  always_comb begin
    seen         = lines_i ^ level_q;
    seen[IX_RI]  = level_q[IX_RI] & ~lines_i[IX_RI];
  end

  always_comb begin
    level_d = lines_i;
    delta_d = (rd_en ? '0 : delta_q) | seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LINE_RST;
      delta_q <= '0;
    end else if (track_en) begin
      level_q <= level_d;
      delta_q <= delta_d;
    end
  end

  always_comb begin
    loop_view         = '0;
    loop_view[IX_DCD] = ctl_i[CB_OUT2];
    loop_view[IX_RI]  = ctl_i[CB_OUT1];
    loop_view[IX_DSR] = ctl_i[CB_DTR];
    loop_view[IX_CTS] = ctl_i[CB_RTS];
  end

  assign rd_data   = loop_i ? {loop_view, 4'b0000} : {level_q, delta_q};
  assign delta_any = track_en & (|delta_q);

endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_cts,
  input  logic             line_dsr,
  input  logic             line_dcd,
  input  logic             line_ri,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  output logic [REG_W-1:0] ctl_rd_data,
  input  logic             stat_rd_en,
  output logic [REG_W-1:0] stat_rd_data,
  output logic             pin_dtr,
  output logic             pin_rts,
  output logic             pin_out1,
  output logic             pin_out2,
  output logic             stat_delta_any
);

  line_nib_t        raw_nib;
  line_nib_t        sync_nib;
  line_nib_t        level_q;
  line_nib_t        delta_q;
  logic [CTL_W-1:0] ctl_q;
  logic             loop_en;
  logic             unused_hi;

  always_comb begin
    raw_nib         = '0;
    raw_nib[IX_CTS] = line_cts;
    raw_nib[IX_DSR] = line_dsr;
    raw_nib[IX_DCD] = line_dcd;
    raw_nib[IX_RI]  = line_ri;
  end

  assign unused_hi = ^ctl_wr_data[REG_W-1:CTL_W];

  msu_sync #(
    .W       (NLINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LINE_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_nib),
    .sync_o  (sync_nib)
  );

  msu_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctl_wr_en),
    .wr_val (ctl_wr_data[CTL_W-1:0]),
    .ctl_q  (ctl_q),
    .loop_o (loop_en),
    .dtr_o  (pin_dtr),
    .rts_o  (pin_rts),
    .out1_o (pin_out1),
    .out2_o (pin_out2)
  );

  msu_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines_i   (sync_nib),
    .loop_i    (loop_en),
    .ctl_i     (ctl_q[CTL_W-2:0]),
    .rd_en     (stat_rd_en),
    .rd_data   (stat_rd_data),
    .delta_any (stat_delta_any),
    .level_q   (level_q),
    .delta_q   (delta_q)
  );

  assign ctl_rd_data = {{(REG_W-CTL_W){1'b0}}, ctl_q};

endmodule

// File: rtl/msu_checker.sv
module msu_checker
  import msu_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      loop,
  input line_nib_t sync_nib,
  input line_nib_t level_q,
  input line_nib_t delta_q,
  input logic      stat_rd_en,
  input logic      ctl_wr_en,
  input logic      wr_loop,
  input logic      wr_dtr,
  input logic      pin_dtr
);

  AST_CTS_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !loop && (sync_nib[IX_CTS] != level_q[IX_CTS]) |=> delta_q[IX_CTS]); // R3

  AST_RING_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !loop && !delta_q[IX_RI] && !(level_q[IX_RI] && !sync_nib[IX_RI]) |=> !delta_q[IX_RI]); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_en && !loop && (sync_nib == level_q) |=> delta_q == '0); // R5

  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_en && !loop && (sync_nib[IX_DSR] != level_q[IX_DSR]) |=> delta_q[IX_DSR]); // R6

  AST_LOOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    loop |=> $stable(level_q) && $stable(delta_q)); // R10

  AST_DTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && !wr_loop |=> pin_dtr == $past(wr_dtr)); // R8

endmodule

bind modem_status_unit msu_checker u_msu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .loop       (loop_en),
  .sync_nib   (sync_nib),
  .level_q    (level_q),
  .delta_q    (delta_q),
  .stat_rd_en (stat_rd_en),
  .ctl_wr_en  (ctl_wr_en),
  .wr_loop    (ctl_wr_data[4]),
  .wr_dtr     (ctl_wr_data[0]),
  .pin_dtr    (pin_dtr)
);

// File: tb/modem_status_unit_bench.sv
module modem_status_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       line_cts, line_dsr, line_dcd, line_ri;
  logic       ctl_wr_en;
  logic [7:0] ctl_wr_data;
  logic [7:0] ctl_rd_data;
  logic       stat_rd_en;
  logic [7:0] stat_rd_data;
  logic       pin_dtr, pin_rts, pin_out1, pin_out2;
  logic       stat_delta_any;

  int n_chk;
  int n_fail;

  modem_status_unit u_modem_status_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_cts       (line_cts),
    .line_dsr       (line_dsr),
    .line_dcd       (line_dcd),
    .line_ri        (line_ri),
    .ctl_wr_en      (ctl_wr_en),
    .ctl_wr_data    (ctl_wr_data),
    .ctl_rd_data    (ctl_rd_data),
    .stat_rd_en     (stat_rd_en),
    .stat_rd_data   (stat_rd_data),
    .pin_dtr        (pin_dtr),
    .pin_rts        (pin_rts),
    .pin_out1       (pin_out1),
    .pin_out2       (pin_out2),
    .stat_delta_any (stat_delta_any)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read strobe for one cycle; returns the value seen during that cycle
  task automatic do_read(output logic [7:0] v);
    @(negedge clk);
    stat_rd_en = 1'b1;
    v = stat_rd_data;
    @(negedge clk);
    stat_rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr};
  endfunction

  task automatic t_reset();
    chk("R1 status after reset", stat_rd_data, 8'hB0);
    chk("R1 control after reset", ctl_rd_data, 8'h08);
    chk("R1 outputs after reset", pins(), 8'h08);
    chk("R1 flag after reset", {7'b0, stat_delta_any}, 8'h00);
  endtask

  task automatic t_track();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b0;
    idle(4);
    chk("R2 R3 cts drop", stat_rd_data, 8'hA1);
    chk("R11 flag raised", {7'b0, stat_delta_any}, 8'h01);
    @(negedge clk); line_dsr = 1'b0;
    idle(4);
    chk("R3 accumulate dsr", stat_rd_data, 8'h83);
    do_read(v);
    chk("R5 read value", v, 8'h83);
    chk("R5 cleared after read", stat_rd_data, 8'h80);
    chk("R11 flag cleared", {7'b0, stat_delta_any}, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    @(negedge clk); line_ri = 1'b1;
    idle(4);
    chk("R4 ring rise no change bit", stat_rd_data, 8'hC0);
    chk("R4 R11 ring rise no flag", {7'b0, stat_delta_any}, 8'h00);
    @(negedge clk); line_ri = 1'b0;
    idle(4);
    chk("R4 ring fall sets bit 2", stat_rd_data, 8'h84);
    do_read(v);
    @(negedge clk); line_dcd = 1'b0;
    idle(4);
    chk("R2 R3 dcd drop", stat_rd_data, 8'h08);
    do_read(v);
    @(negedge clk); line_dcd = 1'b1; line_cts = 1'b1; line_dsr = 1'b1;
    idle(4);
    chk("R3 three lines together", stat_rd_data, 8'hBB);
    do_read(v);
    chk("R5 restored clean", stat_rd_data, 8'hB0);
  endtask

  task automatic t_race();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b0;
    @(negedge clk);
    @(negedge clk); stat_rd_en = 1'b1;
    chk("R2 level not yet updated", stat_rd_data, 8'hB0);
    @(negedge clk); stat_rd_en = 1'b0;
    chk("R6 change kept across clear", stat_rd_data, 8'hA1);
    do_read(v);
    @(negedge clk); line_cts = 1'b1;
    idle(4);
    do_read(v);
    chk("R5 clean before control tests", stat_rd_data, 8'hB0);
  endtask

  task automatic t_ctrl();
    do_write(8'hE7);
    chk("R7 upper bits dropped", ctl_rd_data, 8'h07);
    chk("R8 outputs 0x07", pins(), 8'h07);
    do_write(8'h0A);
    chk("R7 readback 0x0A", ctl_rd_data, 8'h0A);
    chk("R8 outputs 0x0A", pins(), 8'h0A);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b0;
    idle(4);
    chk("R3 pending before loop", stat_rd_data, 8'hA1);
    do_write(8'h1D);
    chk("R10 outputs idle in loop", pins(), 8'h00);
    chk("R11 flag hidden in loop", {7'b0, stat_delta_any}, 8'h00);
    do_read(v);
    chk("R9 loop view 0x1D", v, 8'hE0);
    @(negedge clk); line_dsr = 1'b0;
    idle(4);
    chk("R9 R10 pins ignored in loop", stat_rd_data, 8'hE0);
    do_write(8'h12);
    chk("R9 loop view 0x12", stat_rd_data, 8'h10);
    do_write(8'h08);
    chk("R8 outputs after loop", pins(), 8'h08);
    idle(4);
    chk("R10 held change and new change", stat_rd_data, 8'h83);
    chk("R11 flag after loop", {7'b0, stat_delta_any}, 8'h01);
    do_read(v);
    chk("R5 clear after loop", stat_rd_data, 8'h80);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    line_cts = 1'b1; line_dsr = 1'b1; line_dcd = 1'b1; line_ri = 1'b0;
    ctl_wr_en = 1'b0; ctl_wr_data = 8'h00; stat_rd_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_track();
    t_ring();
    t_race();
    t_ctrl();
    t_loop();
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule